// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block turns a wide bank of general-purpose input pins into a small set of interrupt lines. It offers eight interrupt channels. Each channel picks one pin through an 8-bit index and watches it under its own trigger rule: level-sensitive or single-edge, active high or active low. Every pin passes through a two-flop synchronizer before any channel looks at it. In edge mode a detected transition latches a sticky pending flag that drives the channel's interrupt line until software clears it. In level mode the line simply mirrors the selected pin, inverted if the channel is set active-low.

Software programs the block through a flat 32-bit register port: a write strobe, a byte address and write data, with a combinational readback. One channel sees only one edge direction. To catch both edges of a pin, software routes that pin to two channels, one set for rising and one for falling. An index of 0xFF parks a channel so that it never fires. A filter-select word is kept only as storage and has no effect on the channels.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the trigger-mode word (offset 0x00) reads 0, both selector words (0x04, 0x08) read 0xFFFFFFFF, the filter word (0x0C) reads 0 and all interrupt outputs are low.
- R2: Word 0x00 holds the edge-enable flag of channel c in bit c and its active-low flag in bit 16+c; all its other bits read 0. Word 0x04 holds the selectors of channels 0..3 and word 0x08 those of channels 4..7, each selector 8 bits wide at bit 8*(c mod 4). Word 0x0C stores all 32 bits. Offset 0x10 and any other address read 0. A write takes effect on the clock edge that samples it.
- R3: A channel in level mode (edge flag 0) drives its output equal to the synchronized selected pin, inverted when its active-low flag is 1. A pin change shows on the output after the second rising clock edge.
- R4: A channel whose selector is 0xFF (or names no existing pin) keeps its output low in every mode.
- R5: A channel in edge mode latches a pending flag on a rising transition of its selected pin (active-low flag 0) or a falling transition (active-low flag 1). The output follows the flag, rises after the third clock edge after the pin change, and stays high after the pin returns.
- R6: Writing offset 0x10 with bit c set clears channel c's pending flag; bits written 0 leave flags unchanged. If a new edge is detected in the same cycle as the clear, the flag stays set.
- R7: A write that changes a channel's selector, edge flag or active-low flag clears that channel's pending flag in the same edge, even if an edge is detected then; a write that leaves those fields unchanged keeps the flag. Level-mode channels hold no pending state.
- R8: Routing one pin to two edge-mode channels of opposite polarity reports its rising and falling transitions on separate outputs, independently.
- R9: Writes to the filter word change no interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous GPIO inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the addressed register |
| irq_o | output | 8 | One interrupt line per channel |

## Verification
Readback is combinational from the address and reflects a write from the clock edge that samples it; level outputs move two edges after a pin change and edge outputs three, while clears and reconfiguration act on the write edge itself. The bench drives inputs 5 ns before each rising edge and compares every output at each falling edge against a behavioural model that advances once per rising edge, so every check lands in a settled cycle. Directed checks count these edges explicitly (0 after the second step, 1 after the third for edges), and a long random phase with overlapping clears, edges and reconfiguration exercises the same-cycle priority rules.

// File: rtl/girq_pkg.sv
package girq_pkg;

    localparam int NUM_CH  = 8;
    localparam int SEL_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int POL_LSB = 16;
    localparam int CH_PER_WORD   = DATA_W / SEL_W;
    localparam int NUM_SEL_WORDS = (NUM_CH + CH_PER_WORD - 1) / CH_PER_WORD;

    localparam logic [ADDR_W-1:0] OFF_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SEL  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_FILT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h10;

    localparam logic [SEL_W-1:0] SEL_PARKED = '1;

    typedef struct packed {
        logic             edge_mode;
        logic             act_low;
        logic [SEL_W-1:0] sel;
    } ch_cfg_t;

    localparam ch_cfg_t CFG_RESET = '{edge_mode: 1'b0, act_low: 1'b0, sel: SEL_PARKED};

    function automatic logic [ADDR_W-1:0] sel_word_addr(input int word);
        return ADDR_W'(int'(OFF_SEL) + 4 * word);
    endfunction

    function automatic logic sel_usable(input logic [SEL_W-1:0] sel, input int npins);
        return (sel != SEL_PARKED) && (int'(sel) < npins);
    endfunction

endpackage

// File: rtl/girq_sync.sv
module girq_sync #(
    parameter int NUM_PINS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] cur_o,
    output logic [NUM_PINS-1:0] prev_o
);
    logic [NUM_PINS-1:0] meta_q, sync_q, hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur_o  = sync_q;
    assign prev_o = hist_q;
endmodule

// File: rtl/girq_regs.sv
module girq_regs
    import girq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    output ch_cfg_t [NUM_CH-1:0]       cfg_o,
    output logic [NUM_CH-1:0]          chg_o,
    output logic [NUM_CH-1:0]          clr_o
);
    logic [DATA_W-1:0] filt_q;
    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] sel_words [NUM_SEL_WORDS];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int WORD = c / CH_PER_WORD;
        localparam int LSB  = SEL_W * (c % CH_PER_WORD);
        localparam logic [ADDR_W-1:0] SEL_ADDR = sel_word_addr(WORD);

        ch_cfg_t cfg_q;
        ch_cfg_t cfg_nxt;

        always_comb begin
            cfg_nxt = cfg_q;
            if (we_i && addr_i == OFF_MODE) begin
                cfg_nxt.edge_mode = wdata_i[c];
                cfg_nxt.act_low   = wdata_i[POL_LSB + c];
            end
            if (we_i && addr_i == SEL_ADDR) begin
                cfg_nxt.sel = wdata_i[LSB +: SEL_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) cfg_q <= CFG_RESET;
            else     cfg_q <= cfg_nxt;
        end

        assign cfg_o[c] = cfg_q;
        assign chg_o[c] = (cfg_nxt != cfg_q);
        assign clr_o[c] = we_i && (addr_i == OFF_CLR) && wdata_i[c];
    end

    always_ff @(posedge clk) begin
        if (rst)                             filt_q <= '0;
        else if (we_i && addr_i == OFF_FILT) filt_q <= wdata_i;
    end

    always_comb begin
        mode_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            mode_word[c]           = cfg_o[c].edge_mode;
            mode_word[POL_LSB + c] = cfg_o[c].act_low;
        end
    end

    always_comb begin
        for (int w = 0; w < NUM_SEL_WORDS; w++) sel_words[w] = '0;
        for (int c = 0; c < NUM_CH; c++)
            sel_words[c / CH_PER_WORD][SEL_W * (c % CH_PER_WORD) +: SEL_W] = cfg_o[c].sel;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == OFF_MODE) rdata_o = mode_word;
        if (addr_i == OFF_FILT) rdata_o = filt_q;
        for (int w = 0; w < NUM_SEL_WORDS; w++)
            if (addr_i == sel_word_addr(w)) rdata_o = sel_words[w];
    end
endmodule

// File: rtl/girq_channel.sv
module girq_channel
    import girq_pkg::*;
#(
    parameter int NUM_PINS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  ch_cfg_t             cfg_i,
    input  logic                chg_i,
    input  logic                clr_i,
    input  logic [NUM_PINS-1:0] cur_i,
    input  logic [NUM_PINS-1:0] prev_i,
    output logic                det_o,
    output logic                irq_o
);
    logic usable;
    logic now_v, was_v;
    logic pend_q;

    assign usable = sel_usable(cfg_i.sel, NUM_PINS);
    assign now_v  = usable && cur_i[cfg_i.sel];
    assign was_v  = usable && prev_i[cfg_i.sel];

    assign det_o = cfg_i.edge_mode &&
                   (cfg_i.act_low ? (was_v && !now_v) : (now_v && !was_v));

    always_ff @(posedge clk) begin
        if (rst)                         pend_q <= 1'b0;
        else if (chg_i || !cfg_i.edge_mode) pend_q <= 1'b0;
        else                             pend_q <= (pend_q && !clr_i) || det_o;
    end

    assign irq_o = cfg_i.edge_mode ? pend_q : (usable && (now_v ^ cfg_i.act_low));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import girq_pkg::*;
#(
    parameter int NUM_PINS = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_PINS-1:0]      pin_i,
    input  logic                     reg_we,
    input  logic [girq_pkg::ADDR_W-1:0] reg_addr,
    input  logic [girq_pkg::DATA_W-1:0] reg_wdata,
    output logic [girq_pkg::DATA_W-1:0] reg_rdata,
    output logic [girq_pkg::NUM_CH-1:0] irq_o
);
    logic [NUM_PINS-1:0]  pin_cur, pin_prev;
    ch_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]    chg, clr, det;

    girq_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    girq_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .cfg_o   (cfg),
        .chg_o   (chg),
        .clr_o   (clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        girq_channel #(.NUM_PINS(NUM_PINS)) chan_i (
            .clk    (clk),
            .rst    (rst),
            .cfg_i  (cfg[c]),
            .chg_i  (chg[c]),
            .clr_i  (clr[c]),
            .cur_i  (pin_cur),
            .prev_i (pin_prev),
            .det_o  (det[c]),
            .irq_o  (irq_o[c])
        );
    end
endmodule

// File: rtl/girq_checker.sv
module girq_checker
    import girq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input ch_cfg_t [NUM_CH-1:0] cfg,
    input logic [NUM_CH-1:0]    det,
    input logic [NUM_CH-1:0]    irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
        AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (rst)
            (cfg[c].sel == SEL_PARKED) |-> !irq[c]); // R4
        AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
            (cfg[c].edge_mode && det[c] && !reg_we) |=> irq[c]); // R5
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
            (cfg[c].edge_mode && irq[c] && !reg_we) |=> irq[c]); // R5
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (cfg[c].edge_mode && reg_we && reg_addr == OFF_CLR && reg_wdata[c] && !det[c]) |=> !irq[c]); // R6
        AST_RECONF_QUIET: assert property (@(posedge clk) disable iff (rst)
            (!cfg[c].edge_mode && reg_we && reg_addr == OFF_MODE && reg_wdata[c]) |=> !irq[c]); // R7
    end
endmodule

bind gpio_irq_router girq_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg       (cfg),
    .det       (det),
    .irq       (irq_o)
);

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
    localparam int NP = 256;
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [7:0]    irq_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit running = 1'b0;

    gpio_irq_router #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst(rst), .pin_i(pin), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // behavioural reference state
    bit [NP-1:0] m_a, m_b, m_c;
    bit          m_edge [8];
    bit          m_low  [8];
    int          m_sel  [8];
    bit          m_pend [8];
    bit [31:0]   m_filt;
    int          t_sel;
    bit          t_edge, t_low, t_det, t_clr, t_chg, t_now, t_was, t_ok;

    function automatic bit ok_sel(int s);
        return s != 255 && s < NP;
    endfunction

    function automatic bit exp_irq(int c);
        if (m_edge[c]) return m_pend[c];
        if (!ok_sel(m_sel[c])) return 1'b0;
        return m_b[m_sel[c]] ^ m_low[c];
    endfunction

    function automatic bit [31:0] exp_rd(bit [7:0] a);
        bit [31:0] v = '0;
        case (a)
            8'h00: for (int c = 0; c < 8; c++) begin v[c] = m_edge[c]; v[16+c] = m_low[c]; end
            8'h04: for (int c = 0; c < 4; c++) v[8*c +: 8] = 8'(m_sel[c]);
            8'h08: for (int c = 0; c < 4; c++) v[8*c +: 8] = 8'(m_sel[c+4]);
            8'h0C: v = m_filt;
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_a = '0; m_b = '0; m_c = '0; m_filt = '0;
            for (int c = 0; c < 8; c++) begin
                m_edge[c] = 0; m_low[c] = 0; m_sel[c] = 255; m_pend[c] = 0;
            end
        end else begin
            for (int c = 0; c < 8; c++) begin
                t_sel = m_sel[c]; t_edge = m_edge[c]; t_low = m_low[c];
                if (reg_we && reg_addr == 8'h00) begin
                    t_edge = reg_wdata[c]; t_low = reg_wdata[16+c];
                end
                if (reg_we && reg_addr == 8'(4 + 4*(c/4)))
                    t_sel = int'((reg_wdata >> (8*(c%4))) & 32'hFF);
                t_ok  = ok_sel(m_sel[c]);
                t_now = t_ok ? m_b[m_sel[c]] : 1'b0;
                t_was = t_ok ? m_c[m_sel[c]] : 1'b0;
                t_det = m_edge[c] && (m_low[c] ? (t_was && !t_now) : (t_now && !t_was));
                t_chg = (t_sel != m_sel[c]) || (t_edge != m_edge[c]) || (t_low != m_low[c]);
                t_clr = reg_we && reg_addr == 8'h10 && reg_wdata[c];
                if (t_chg || !m_edge[c]) m_pend[c] = 0;
                else m_pend[c] = (m_pend[c] && !t_clr) || t_det;
                m_sel[c] = t_sel; m_edge[c] = t_edge; m_low[c] = t_low;
            end
            if (reg_we && reg_addr == 8'h0C) m_filt = reg_wdata;
            m_c = m_b; m_b = m_a; m_a = pin;
        end
    end

    // every-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (running && !rst) begin
            for (int c = 0; c < 8; c++) begin
                n_chk++;
                if (irq_o[c] !== exp_irq(c)) begin
                    n_err++;
                    $display("FAIL %s ch%0d irq actual %0b expected %0b (cycle %0d)",
                             !ok_sel(m_sel[c]) ? "R4" : (m_edge[c] ? "R5" : "R3"),
                             c, irq_o[c], exp_irq(c), cyc);
                end
            end
            n_chk++;
            if (reg_rdata !== exp_rd(reg_addr)) begin
                n_err++;
                $display("FAIL R2 rdata @%02h actual %08h expected %08h", reg_addr, reg_rdata, exp_rd(reg_addr));
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #5;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        while (cyc < WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: cycles actual %0d expected below %0d", cyc, WATCHDOG);
        finish_run();
    end

    logic [7:0] snap;

    initial begin
        steps(3);
        rst = 1'b0;
        running = 1'b1;
        step();

        // R1 reset state
        rd("R1 mode word", 8'h00, 32'h0);
        rd("R1 selector word 0", 8'h04, 32'hFFFF_FFFF);
        rd("R1 selector word 1", 8'h08, 32'hFFFF_FFFF);
        rd("R1 filter word", 8'h0C, 32'h0);
        chk("R1 irq", {24'h0, irq_o}, 32'h0);

        // R2 layout and readback
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R2 mode reserved bits", 8'h00, 32'h00FF_00FF);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0302_0100);
        rd("R2 selector bytes", 8'h04, 32'h0302_0100);
        wr(8'h0C, 32'hA5A5_5A5A);
        rd("R2 filter storage", 8'h0C, 32'hA5A5_5A5A);
        rd("R2 clear reads zero", 8'h10, 32'h0);
        rd("R2 unmapped reads zero", 8'h14, 32'h0);

        // R3 level mode, two-edge latency, polarity
        pin[2] = 1'b1;
        step();
        chk("R3 level after one edge", {31'h0, irq_o[2]}, 32'h0);
        step();
        chk("R3 level after two edges", {31'h0, irq_o[2]}, 32'h1);
        wr(8'h00, 32'h0004_0000);
        chk("R3 active-low inverts", {31'h0, irq_o[2]}, 32'h0);

        // R4 parked channel stays quiet even active-low
        wr(8'h08, 32'hFFFF_FF07);
        wr(8'h00, 32'h0024_0000);
        steps(2);
        chk("R4 parked active-low", {31'h0, irq_o[5]}, 32'h0);
        pin[7] = 1'b1;
        steps(2);
        chk("R3 channel 4 follows pin 7", {31'h0, irq_o[4]}, 32'h1);

        // R5 rising edge, three-edge latency, sticky
        wr(8'h00, 32'h0024_0001);
        pin[0] = 1'b1;
        steps(2);
        chk("R5 edge not yet latched", {31'h0, irq_o[0]}, 32'h0);
        step();
        chk("R5 edge latched", {31'h0, irq_o[0]}, 32'h1);
        pin[0] = 1'b0;
        steps(4);
        chk("R5 pending sticky", {31'h0, irq_o[0]}, 32'h1);

        // R6 clear
        wr(8'h10, 32'h0);
        chk("R6 zero clear no effect", {31'h0, irq_o[0]}, 32'h1);
        wr(8'h10, 32'h1);
        chk("R6 clear drops pending", {31'h0, irq_o[0]}, 32'h0);

        // R7 reconfiguration
        pin[0] = 1'b1;
        steps(3);
        chk("R7 pending before rewrite", {31'h0, irq_o[0]}, 32'h1);
        wr(8'h00, 32'h0024_0001);
        chk("R7 identical rewrite keeps", {31'h0, irq_o[0]}, 32'h1);
        wr(8'h04, 32'h0302_0101);
        chk("R7 selector change clears", {31'h0, irq_o[0]}, 32'h0);

        // R8 both edges through two channels
        wr(8'h08, 32'h0909_FF07);
        wr(8'h00, 32'h00A4_00C1);
        pin[9] = 1'b1;
        steps(3);
        chk("R8 rise channel", {31'h0, irq_o[6]}, 32'h1);
        chk("R8 fall channel idle", {31'h0, irq_o[7]}, 32'h0);
        wr(8'h10, 32'h40);
        pin[9] = 1'b0;
        steps(3);
        chk("R8 fall channel", {31'h0, irq_o[7]}, 32'h1);
        chk("R8 rise channel cleared", {31'h0, irq_o[6]}, 32'h0);

        // R9 filter word is storage only
        snap = irq_o;
        wr(8'h0C, 32'hFFFF_FFFF);
        chk("R9 filter write no effect", {24'h0, irq_o}, {24'h0, snap});
        wr(8'h0C, 32'h0);
        chk("R9 filter cleared no effect", {24'h0, irq_o}, {24'h0, snap});

        // random phase, compared every cycle by the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 2) == 0) pin[$urandom_range(0, 15)] ^= 1'b1;
            if ($urandom_range(0, 7) == 0) begin
                reg_we = 1'b1;
                case ($urandom_range(0, 5))
                    0: begin reg_addr = 8'h00; reg_wdata = $urandom & 32'h00FF_00FF; end
                    1: begin reg_addr = 8'h04;
                             reg_wdata = ($urandom_range(0, 3) == 0) ? 32'hFF0F_FF0F & $urandom | 32'hFF00_0000
                                                                      : $urandom & 32'h0F0F_0F0F; end
                    2: begin reg_addr = 8'h08; reg_wdata = $urandom & 32'h0F0F_0F0F; end
                    3: begin reg_addr = 8'h10; reg_wdata = $urandom; end
                    4: begin reg_addr = 8'h0C; reg_wdata = $urandom; end
                    default: begin reg_addr = 8'h14; reg_wdata = $urandom; end
                endcase
            end else begin
                reg_we = 1'b0;
                reg_addr = 8'(4 * $urandom_range(0, 5));
            end
            step();
        end
        reg_we = 1'b0;
        step();
        finish_run();
    end
endmodule